// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Aggregator

This block collects thirty-two external interrupt request lines and folds them into two processor interrupt lines, an urgent line and an ordinary line. Each request line is first brought into the local clock domain and then judged against its own settings. The source can be edge or level sensitive, and it can be active on the high level or rising edge, or on the low level or falling edge. When a source triggers, it raises a pending bit that software can see. The pending bit is gated by a per-source enable and steered by a per-source route bit to one of the two outputs.

Software uses a small word-addressed register bus. Writes take effect on the clock edge, and reads come back combinationally in the same cycle. A pending bit is cleared by writing a one to it. A level-sensitive pending bit cannot be cleared while its line is still active, even when that source is disabled. This means a handler must silence the device before it acknowledges the interrupt.

Top module: `irqc_top`

## Requirements
- R1: Source n (the value on `irq_in[n]`) owns bit 31−n of every per-source register, so source 0 is the most significant bit.
- R2: Word offsets are 0x0 pending, 0x2 enable, 0x3 route, 0x4 sense, 0x5 mode, 0x6 gated pending. After reset all of these read zero. Offset 0x1 and offsets 0x7 to 0xF always read zero. Enable, route, sense and mode read back the last value written to them.
- R3: Writing to offset 0x0 clears each pending bit whose data bit is 1. Data bits of 0 leave the matching pending bits unchanged.
- R4: A mode bit of 1 makes the source edge sensitive. One transition in the chosen direction sets the pending bit, which then stays set until it is cleared. A transition in the other direction sets nothing.
- R5: A sense bit of 1 selects the high level or rising edge. A sense bit of 0 selects the low level or falling edge. A mode bit of 0 makes the source level sensitive, and the pending bit is set in every cycle that the line is at its active level.
- R6: While a level source's line stays active, a clear write to its pending bit has no effect, whether its enable bit is 1 or 0.
- R7: Offset 0x6 reads the bitwise AND of pending and enable.
- R8: `irq_crit` is a registered OR of the gated pending bits whose route bit is 1. `irq_norm` is the same for route bit 0. Each follows the register state one clock later.
- R9: A change on an input reaches the pending register on the third rising clock edge after the change, through a two-stage synchroniser.
- R10: If a clear write and a new trigger event on the same bit meet on one clock edge, the bit stays set.
- R11: Writes to offset 0x6 or to any unimplemented offset change no readable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | External request lines, bit n is source n |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_crit | output | 1 | Urgent processor interrupt |
| irq_norm | output | 1 | Ordinary processor interrupt |

## Verification
The hardest case to reach from the pins is a clear write and a fresh edge landing on exactly the same clock edge. The bench reaches it by counting edges: it drives the input on a falling clock edge and asserts the clear write two cycles later, so the write lands on the third rising edge, the same edge on which the synchronised event reaches the pending bit. A second hard case is a disabled level source that is still asserted while software clears it. The bench sweeps every source through all four sense and mode combinations, and in each level pass it repeats the clear with the enable bit at zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_GATED  = 4'h6;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] active, rise, fall, edge_hit, hit;

  always_comb begin
    active   = ~(lvl ^ sense);
    rise     = lvl & ~prev_q;
    fall     = ~lvl & prev_q;
    edge_hit = (sense & rise) | (~sense & fall);
    hit      = (mode & edge_hit) | (~mode & active);
    // a new event outranks a clear on the same edge
    pend_d   = hit | (pend_q & ~clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      pend,
  output logic [W-1:0]      enable,
  output logic [W-1:0]      route,
  output logic [W-1:0]      sense,
  output logic [W-1:0]      mode,
  output logic [W-1:0]      clr_mask,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] enable_q, route_q, sense_q, mode_q;
  logic         en_we, rt_we, se_we, md_we;

  always_comb begin
    en_we    = bus_wr && (bus_addr == OFS_ENABLE);
    rt_we    = bus_wr && (bus_addr == OFS_ROUTE);
    se_we    = bus_wr && (bus_addr == OFS_SENSE);
    md_we    = bus_wr && (bus_addr == OFS_MODE);
    clr_mask = (bus_wr && (bus_addr == OFS_PEND)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      route_q  <= '0;
      sense_q  <= '0;
      mode_q   <= '0;
    end else begin
      if (en_we) enable_q <= bus_wdata;
      if (rt_we) route_q  <= bus_wdata;
      if (se_we) sense_q  <= bus_wdata;
      if (md_we) mode_q   <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_PEND:   rdata = pend;
      OFS_ENABLE: rdata = enable_q;
      OFS_ROUTE:  rdata = route_q;
      OFS_SENSE:  rdata = sense_q;
      OFS_MODE:   rdata = mode_q;
      OFS_GATED:  rdata = pend & enable_q;
      default:    rdata = '0;
    endcase
  end

  assign enable = enable_q;
  assign route  = route_q;
  assign sense  = sense_q;
  assign mode   = mode_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_crit,
  output logic               irq_norm
);
  localparam int unsigned MSB = NUM_SRC - 1;

  logic               rst_ns;
  logic [NUM_SRC-1:0] raw_lvl, sync_lvl;
  logic [NUM_SRC-1:0] status, enable, crit_sel, polarity, trigger, clr_mask;
  logic [NUM_SRC-1:0] gated;
  logic               crit_d, norm_d, crit_q, norm_q;

  // source n lands on register bit MSB-n
  generate
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
      assign raw_lvl[MSB-n] = irq_in[n];
    end
  endgenerate

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .async_in(raw_lvl), .sync_out(sync_lvl)
  );

  irqc_detect #(.W(NUM_SRC)) u_detect (
    .clk(clk), .rst_n(rst_ns), .lvl(sync_lvl), .sense(polarity),
    .mode(trigger), .clr_mask(clr_mask), .pend(status)
  );

  irqc_regs #(.W(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_ns), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend(status), .enable(enable), .route(crit_sel),
    .sense(polarity), .mode(trigger), .clr_mask(clr_mask), .rdata(bus_rdata)
  );

  always_comb begin
    gated  = status & enable;
    crit_d = |(gated & crit_sel);
    norm_d = |(gated & ~crit_sel);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      crit_q <= 1'b0;
      norm_q <= 1'b0;
    end else begin
      crit_q <= crit_d;
      norm_q <= norm_d;
    end
  end

  assign irq_crit = crit_q;
  assign irq_norm = norm_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic              irq_crit,
  input logic              irq_norm,
  input logic [W-1:0]      status,
  input logic [W-1:0]      enable,
  input logic [W-1:0]      crit_sel,
  input logic [W-1:0]      polarity,
  input logic [W-1:0]      trigger,
  input logic [W-1:0]      sync_lvl
);
  logic [W-1:0] lvl_act, clr_req;

  always_comb begin
    lvl_act = ~trigger & ~(sync_lvl ^ polarity);
    clr_req = (bus_wr && (bus_addr == OFS_PEND)) ? bus_wdata : '0;
  end

  AST_LEVEL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(lvl_act)) == $past(lvl_act))); // R6

  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~status) & ~$past(clr_req)) == '0)); // R3

  AST_GATED_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_GATED) |-> (bus_rdata == (status & enable))); // R7

  AST_VOID_OFFSETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == 4'h1) || (bus_addr > OFS_GATED)) |-> (bus_rdata == '0)); // R2

  AST_CRIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_crit == |($past(status & enable & crit_sel)))); // R8

  AST_NORM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_norm == |($past(status & enable & ~crit_sel)))); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(enable) && $stable(crit_sel) && $stable(polarity)
                 && $stable(trigger))); // R11
endmodule

bind irqc_top irqc_checker #(.W(NUM_SRC)) u_irqc_checker (
  .clk(clk), .rst_n(rst_ns), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_crit(irq_crit),
  .irq_norm(irq_norm), .status(status), .enable(enable),
  .crit_sel(crit_sel), .polarity(polarity), .trigger(trigger),
  .sync_lvl(sync_lvl)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_crit, irq_norm;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  irqc_top u_irqc_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_crit(irq_crit), .irq_norm(irq_norm)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, m;
    rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    // R2 reset state, read while held in reset
    for (int a = 0; a < 16; a++) begin
      bus_addr = a[3:0];
      #1 check($sformatf("R2 reset read ofs %0d", a), bus_rdata, 32'h0);
    end
    check("R8 reset outputs", {30'h0, irq_crit, irq_norm}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    // all level-high, clear anything latched while low-active
    wr(4'h4, 32'hFFFF_FFFF);
    idle(4);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R3 clear all", v, 32'h0);
    // R2 readback of writable registers
    wr(4'h2, 32'hA5A5_0F0F); rd(4'h2, v); check("R2 enable readback", v, 32'hA5A5_0F0F);
    wr(4'h3, 32'h1234_5678); rd(4'h3, v); check("R2 route readback", v, 32'h1234_5678);
    // R11 writes to read-only/void offsets
    wr(4'h6, 32'hFFFF_FFFF); wr(4'h7, 32'hFFFF_FFFF); wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h2, v); check("R11 enable untouched", v, 32'hA5A5_0F0F);
    rd(4'h3, v); check("R11 route untouched", v, 32'h1234_5678);
    rd(4'h4, v); check("R11 sense untouched", v, 32'hFFFF_FFFF);
    rd(4'h5, v); check("R11 mode untouched", v, 32'h0);
    rd(4'h7, v); check("R2 void offset", v, 32'h0);
    wr(4'h2, 32'h0); wr(4'h3, 32'h0);

    // sweep: every source, every sense/mode pair
    for (int n = 0; n < 32; n++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic pol, trg, cr;
        pol = cfg[0]; trg = cfg[1]; cr = n[0];
        m = 32'h1 << (31 - n);   // R1 mapping
        irq_in[n] = ~pol;
        wr(4'h4, (32'hFFFF_FFFF & ~m) | (pol ? m : 32'h0));
        wr(4'h5, trg ? m : 32'h0);
        idle(5);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check($sformatf("R5 idle src%0d cfg%0d", n, cfg), v, 32'h0);
        irq_in[n] = pol;
        idle(5);
        rd(4'h0, v); check($sformatf("R1 R4 R5 trigger src%0d cfg%0d", n, cfg), v, m);
        wr(4'h2, m); wr(4'h3, cr ? m : 32'h0);
        idle(2);
        check($sformatf("R8 lines src%0d cfg%0d", n, cfg),
              {30'h0, irq_crit, irq_norm}, {30'h0, cr, ~cr});
        rd(4'h6, v); check($sformatf("R7 gated src%0d cfg%0d", n, cfg), v, m);
        irq_in[n] = ~pol;
        idle(5);
        rd(4'h0, v); check($sformatf("R4 held src%0d cfg%0d", n, cfg), v, m);
        wr(4'h0, ~m);
        rd(4'h0, v); check($sformatf("R3 zero keeps src%0d cfg%0d", n, cfg), v, m);
        wr(4'h0, m);
        rd(4'h0, v); check($sformatf("R3 one clears src%0d cfg%0d", n, cfg), v, 32'h0);
        idle(2);
        check($sformatf("R8 lines drop src%0d cfg%0d", n, cfg),
              {30'h0, irq_crit, irq_norm}, 32'h0);
        if (trg) begin
          idle(3);
          rd(4'h0, v); check($sformatf("R4 no opposite edge src%0d cfg%0d", n, cfg), v, 32'h0);
        end else begin
          irq_in[n] = pol;
          wr(4'h2, 32'h0);
          idle(5);
          wr(4'h0, m);
          rd(4'h0, v); check($sformatf("R6 clear blocked src%0d cfg%0d", n, cfg), v, m);
          irq_in[n] = ~pol;
          idle(5);
          wr(4'h0, m);
          rd(4'h0, v); check($sformatf("R6 clear after release src%0d cfg%0d", n, cfg), v, 32'h0);
        end
        irq_in[n] = 1'b0;
        wr(4'h4, 32'hFFFF_FFFF); wr(4'h5, 32'h0);
        wr(4'h2, 32'h0); wr(4'h3, 32'h0);
        idle(5);
        wr(4'h0, 32'hFFFF_FFFF);
      end
    end

    // R9 latency: source 5, rising edge
    m = 32'h1 << 26;
    wr(4'h5, m); wr(4'h2, m);
    idle(4); wr(4'h0, 32'hFFFF_FFFF);
    bus_addr = 4'h0;
    @(negedge clk) irq_in[5] = 1'b1;           // before edge 1
    @(negedge clk);                             // after edge 1
    @(negedge clk); #1 check("R9 not yet at edge 2", bus_rdata, 32'h0);
    @(negedge clk); #1 check("R9 set at edge 3", bus_rdata, m);
    check("R8 line not yet", {31'h0, irq_norm}, 32'h0);
    @(negedge clk); #1 check("R8 line one edge later", {31'h0, irq_norm}, 32'h1);

    // R10 clear write meets a new edge on the same clock edge
    @(negedge clk) irq_in[5] = 1'b0;
    idle(4);
    rd(4'h0, v); check("R10 pre-pending", v, m);
    @(negedge clk) irq_in[5] = 1'b1;           // before edge 1
    @(negedge clk);
    @(negedge clk) begin                         // write lands on edge 3
      bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = m;
    end
    @(negedge clk) bus_wr = 1'b0;
    #1 check("R10 event beats clear", bus_rdata, m);
    wr(4'h0, m);
    rd(4'h0, v); check("R10 later clear works", v, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule